// File: doc/BRIEF.md
# Interval Timer Bus Control

This block is the processor-facing front end of a three-channel interval timer. It sits between an 8-bit register bus and three counter channels, which are built elsewhere. The bus sees four byte-wide ports. Ports 0, 1 and 2 carry the data of channels 0, 1 and 2, and port 3 accepts commands. A command either programs a channel's counting mode and byte access scheme, freezes one or more live counts for a consistent read, or captures a channel's status byte for read-back. Data-port writes assemble a 16-bit reload value and hand it to the channel with a one-cycle load pulse. Data-port reads return the byte that the access scheme and any pending latch select.

A separate system control register drives the gate of channel 2 and the enable of the speaker path. The same register reads back the live output of channel 2.

Top module: `tmr_bus_ctl`

## Requirements
- R1: After a synchronous active-low reset, every channel has mode 0, access code 11 (low then high), reload 0 and no load pulse, and both the channel 2 gate and the speaker enable are 0.
- R2: Bus addresses 0 to 2 select the data port of channels 0 to 2, and address 3 is the command port. A read of address 3 returns 0.
- R3: A command whose upper nibble is 4*ch+1, 4*ch+2 or 4*ch+3 (ch = 0 to 2) sets channel ch to low-byte-only, high-byte-only or low-then-high access. The same command stores bits 3:1 as the channel mode, which appears on that channel's mode output on the following cycle.
- R4: In low-byte-only access, a data write of d sets the reload value to {8'h00, d} and pulses the channel's load output for one cycle, both visible on the cycle after the write.
- R5: In high-byte-only access, a data write of d sets the reload value to {d, 8'h00}, together with the load pulse.
- R6: In low-then-high access, the first data write is held as the low byte with no load pulse. The second write d forms the reload {d, low} and pulses load.
- R7: Without a latch, a data read returns the live count: the low byte in low-only access, the high byte in high-only access, and low then high alternating in low-then-high access, starting with low after each access command.
- R8: Upper nibble 4*ch+0 freezes channel ch's count. Reads return the frozen value until it has been fully read in the current access scheme: one byte in the single-byte schemes, two in low-then-high. Further latch commands to that channel are ignored until then.
- R9: Upper nibble 1101 freezes the counts of all three channels at once.
- R10: Upper nibble 1110 with command bits 2:1 = ch captures channel ch's status byte. In that byte, bit 7 is 0, bit 6 is the channel's loaded input, bits 5:4 are the access code (01 high only, 10 low only, 11 both), bits 3:1 are the mode, and bit 0 is 0. The next read returns the status byte, ahead of any frozen count bytes. A second status capture is ignored while one is pending.
- R11: An access command discards a half-written 16-bit reload and any pending count or status latch of its channel.
- R12: The system control register drives the channel 2 gate from bit 0 and the speaker enable from bit 1. Its read value carries bit 0 and bit 1 back, returns the channel 2 output in bit 5, and returns 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 2 | Port select: 0-2 channel data, 3 command |
| bus_wr_i | input | 1 | Write strobe, one cycle per byte |
| bus_rd_i | input | 1 | Read strobe, one cycle per byte; advances read sequencing |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed port, combinational |
| ch_count_i | input | 48 | Live counts, channel c at bits 16c+15:16c |
| ch_loaded_i | input | 3 | Per-channel count loaded flag, reported in status |
| ch2_out_i | input | 1 | Channel 2 output level |
| ch_mode_o | output | 9 | Mode per channel, channel c at bits 3c+2:3c |
| ch_reload_o | output | 48 | Reload value per channel, same packing as counts |
| ch_load_o | output | 3 | One-cycle pulse when a channel's reload is complete |
| sysctl_wr_i | input | 1 | Write strobe of the system control register |
| sysctl_wdata_i | input | 2 | Bit 1 speaker enable, bit 0 channel 2 gate |
| sysctl_rdata_o | output | 8 | System control read value |
| gate2_o | output | 1 | Gate of channel 2 |
| spkr_en_o | output | 1 | Speaker path enable |

## Verification
A wrong byte toggle shows at the ports on the very next data read, as a high byte where a low byte was expected. A stuck latch flag shows one read later, as a frozen value returned once the live count has moved on. A lost or duplicated load pulse, or a misassembled reload, is visible on the cycle after the completing write. A corrupted status capture appears on the read that follows the status command, because every field of that byte is compared against the access code and mode that the bench just programmed.

// File: rtl/tmr_bus_pkg.sv
// Shared constants and types of the interval timer bus control.
// Assumes three channels with 16-bit counts carried over an 8-bit bus.
package tmr_bus_pkg;
    localparam int NCH    = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    // Byte access scheme; the encoding is the one reported in the status byte.
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_MSB  = 2'b01,
        ACC_LSB  = 2'b10,
        ACC_BOTH = 2'b11
    } acc_e;
endpackage

// File: rtl/tmr_cmd_decode.sv
// Command decoder: turns one command byte into per-channel action strobes.
// Assumes cmd_vld_i is high for exactly the cycle of a command-port write.
// Bit 0 of the command carries no meaning and is not brought in.
module tmr_cmd_decode
    import tmr_bus_pkg::*;
(
    input  logic           cmd_vld_i,
    input  logic [7:1]     cmd_i,
    output logic [NCH-1:0] acc_set_o,
    output logic [NCH-1:0] latch_cnt_o,
    output logic [NCH-1:0] latch_sts_o,
    output acc_e           acc_o,
    output logic [MODE_W-1:0] mode_o
);
    logic [3:0] nib;
    assign nib    = cmd_i[7:4];
    assign mode_o = cmd_i[3:1];

    // Map the low two nibble bits to the access scheme.
    always_comb begin
        case (nib[1:0])
            2'b01:   acc_o = ACC_LSB;
            2'b10:   acc_o = ACC_MSB;
            default: acc_o = ACC_BOTH;
        endcase
    end

    // Raise the strobe of the addressed channel(s) for the decoded operation.
    always_comb begin
        acc_set_o   = '0;
        latch_cnt_o = '0;
        latch_sts_o = '0;
        if (cmd_vld_i) begin
            if (nib[3:2] != 2'b11) begin
                for (int c = 0; c < NCH; c++) begin
                    if (nib[3:2] == c[1:0]) begin
                        if (nib[1:0] == 2'b00) latch_cnt_o[c] = 1'b1;
                        else                   acc_set_o[c]   = 1'b1;
                    end
                end
            end else if (nib == 4'hD) begin
                latch_cnt_o = '1;
            end else if (nib == 4'hE) begin
                for (int c = 0; c < NCH; c++)
                    if (cmd_i[2:1] == c[1:0]) latch_sts_o[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
// One channel's data port: reload assembly, byte sequencing, count and status latches.
// Assumes at most one of the strobe inputs is high in any cycle.
module tmr_chan_port
    import tmr_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_set_i,
    input  acc_e              acc_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              latch_cnt_i,
    input  logic              latch_sts_i,
    input  logic              wr_stb_i,
    input  logic              rd_stb_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              loaded_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              load_o,
    output logic [BYTE_W-1:0] rdata_o
);
    acc_e              acc_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  reload_q;
    logic              load_q;
    logic              wr_lo_pend_q;
    logic [BYTE_W-1:0] wr_lo_q;
    logic              rd_hi_q;
    logic              cnt_latched_q;
    logic [CNT_W-1:0]  latch_val_q;
    logic              latch_hi_q;
    logic              sts_pend_q;
    logic [BYTE_W-1:0] sts_val_q;

    logic [CNT_W-1:0]  rd_src;
    logic              rd_hi_sel;

    assign mode_o   = mode_q;
    assign reload_o = reload_q;
    assign load_o   = load_q;

    // Select the read byte: pending status first, then frozen or live count.
    always_comb begin
        rd_src = cnt_latched_q ? latch_val_q : count_i;
        case (acc_q)
            ACC_MSB: rd_hi_sel = 1'b1;
            ACC_LSB: rd_hi_sel = 1'b0;
            default: rd_hi_sel = cnt_latched_q ? latch_hi_q : rd_hi_q;
        endcase
        if (sts_pend_q)     rdata_o = sts_val_q;
        else if (rd_hi_sel) rdata_o = rd_src[CNT_W-1:BYTE_W];
        else                rdata_o = rd_src[BYTE_W-1:0];
    end

    // Channel state update for commands, writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q         <= ACC_BOTH;
            mode_q        <= '0;
            reload_q      <= '0;
            load_q        <= 1'b0;
            wr_lo_pend_q  <= 1'b0;
            wr_lo_q       <= '0;
            rd_hi_q       <= 1'b0;
            cnt_latched_q <= 1'b0;
            latch_val_q   <= '0;
            latch_hi_q    <= 1'b0;
            sts_pend_q    <= 1'b0;
            sts_val_q     <= '0;
        end else begin
            load_q <= 1'b0;
            if (acc_set_i) begin
                acc_q         <= acc_i;
                mode_q        <= mode_i;
                wr_lo_pend_q  <= 1'b0;
                rd_hi_q       <= 1'b0;
                cnt_latched_q <= 1'b0;
                latch_hi_q    <= 1'b0;
                sts_pend_q    <= 1'b0;
            end else if (latch_cnt_i) begin
                if (!cnt_latched_q) begin
                    latch_val_q   <= count_i;
                    cnt_latched_q <= 1'b1;
                    latch_hi_q    <= 1'b0;
                end
            end else if (latch_sts_i) begin
                if (!sts_pend_q) begin
                    sts_val_q  <= {1'b0, loaded_i, acc_q, mode_q, 1'b0};
                    sts_pend_q <= 1'b1;
                end
            end else if (wr_stb_i) begin
                case (acc_q)
                    ACC_LSB: begin
                        reload_q <= {{BYTE_W{1'b0}}, wdata_i};
                        load_q   <= 1'b1;
                    end
                    ACC_MSB: begin
                        reload_q <= {wdata_i, {BYTE_W{1'b0}}};
                        load_q   <= 1'b1;
                    end
                    default: begin
                        if (!wr_lo_pend_q) begin
                            wr_lo_q      <= wdata_i;
                            wr_lo_pend_q <= 1'b1;
                        end else begin
                            reload_q     <= {wdata_i, wr_lo_q};
                            wr_lo_pend_q <= 1'b0;
                            load_q       <= 1'b1;
                        end
                    end
                endcase
            end else if (rd_stb_i) begin
                if (sts_pend_q) begin
                    sts_pend_q <= 1'b0;
                end else if (cnt_latched_q) begin
                    if (acc_q == ACC_BOTH && !latch_hi_q) begin
                        latch_hi_q <= 1'b1;
                    end else begin
                        cnt_latched_q <= 1'b0;
                        latch_hi_q    <= 1'b0;
                    end
                end else if (acc_q == ACC_BOTH) begin
                    rd_hi_q <= ~rd_hi_q;
                end
            end
        end
    end

    // R6: a load pulse only ever follows a data write.
    a_r6_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> $past(wr_stb_i));
    // R8: a frozen count does not move while it stays latched.
    a_r8_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_latched_q && $past(cnt_latched_q)) |-> $stable(latch_val_q));
    // R10: a pending status byte is held until it is read.
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_pend_q && $past(sts_pend_q)) |-> $stable(sts_val_q));
    // R3: the access scheme is always a defined one.
    a_r3_access_defined: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q != ACC_NONE);
endmodule

// File: rtl/tmr_sysctl_reg.sv
// System control register: channel 2 gate, speaker enable, channel 2 output read-back.
// Assumes the write strobe is one cycle wide.
module tmr_sysctl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    input  logic       ch2_out_i,
    output logic [7:0] rdata_o,
    output logic       gate2_o,
    output logic       spkr_en_o
);
    // Capture the two control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate2_o   <= 1'b0;
            spkr_en_o <= 1'b0;
        end else if (wr_i) begin
            gate2_o   <= wdata_i[0];
            spkr_en_o <= wdata_i[1];
        end
    end

    // Assemble the read value with the channel 2 output in bit 5.
    assign rdata_o = {2'b00, ch2_out_i, 3'b000, spkr_en_o, gate2_o};

    // R12: the control bits change only on a register write.
    a_r12_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
        (gate2_o != $past(gate2_o) || spkr_en_o != $past(spkr_en_o)) |-> $past(wr_i) || $past(!rst_n));
endmodule

// File: rtl/tmr_bus_ctl.sv
// Top of the interval timer bus control: decodes the four bus ports,
// runs one data port per channel and holds the system control register.
// Assumes bus_rd_i and bus_wr_i are never high in the same cycle.
module tmr_bus_ctl
    import tmr_bus_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              bus_addr_i,
    input  logic                    bus_wr_i,
    input  logic                    bus_rd_i,
    input  logic [BYTE_W-1:0]       bus_wdata_i,
    output logic [BYTE_W-1:0]       bus_rdata_o,
    input  logic [NCH*CNT_W-1:0]    ch_count_i,
    input  logic [NCH-1:0]          ch_loaded_i,
    input  logic                    ch2_out_i,
    output logic [NCH*MODE_W-1:0]   ch_mode_o,
    output logic [NCH*CNT_W-1:0]    ch_reload_o,
    output logic [NCH-1:0]          ch_load_o,
    input  logic                    sysctl_wr_i,
    input  logic [1:0]              sysctl_wdata_i,
    output logic [7:0]              sysctl_rdata_o,
    output logic                    gate2_o,
    output logic                    spkr_en_o
);
    localparam logic [1:0] CMD_ADDR = 2'(NCH);

    logic [NCH-1:0]    acc_set, latch_cnt, latch_sts;
    acc_e              cmd_acc;
    logic [MODE_W-1:0] cmd_mode;
    logic [BYTE_W-1:0] ch_rdata [NCH];

    tmr_cmd_decode u_dec (
        .cmd_vld_i   (bus_wr_i && bus_addr_i == CMD_ADDR),
        .cmd_i       (bus_wdata_i[7:1]),
        .acc_set_o   (acc_set),
        .latch_cnt_o (latch_cnt),
        .latch_sts_o (latch_sts),
        .acc_o       (cmd_acc),
        .mode_o      (cmd_mode)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_chan_port u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .acc_set_i   (acc_set[c]),
            .acc_i       (cmd_acc),
            .mode_i      (cmd_mode),
            .latch_cnt_i (latch_cnt[c]),
            .latch_sts_i (latch_sts[c]),
            .wr_stb_i    (bus_wr_i && bus_addr_i == 2'(c)),
            .rd_stb_i    (bus_rd_i && bus_addr_i == 2'(c)),
            .wdata_i     (bus_wdata_i),
            .count_i     (ch_count_i[c*CNT_W +: CNT_W]),
            .loaded_i    (ch_loaded_i[c]),
            .mode_o      (ch_mode_o[c*MODE_W +: MODE_W]),
            .reload_o    (ch_reload_o[c*CNT_W +: CNT_W]),
            .load_o      (ch_load_o[c]),
            .rdata_o     (ch_rdata[c])
        );
    end

    // Route the addressed channel's byte to the bus; the command port reads 0.
    always_comb begin
        bus_rdata_o = '0;
        for (int c = 0; c < NCH; c++)
            if (bus_addr_i == c[1:0]) bus_rdata_o = ch_rdata[c];
    end

    tmr_sysctl_reg u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (sysctl_wr_i),
        .wdata_i   (sysctl_wdata_i),
        .ch2_out_i (ch2_out_i),
        .rdata_o   (sysctl_rdata_o),
        .gate2_o   (gate2_o),
        .spkr_en_o (spkr_en_o)
    );

    // R3: one command programs at most one channel.
    a_r3_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_set));
    // R10: a status capture addresses at most one channel.
    a_r10_single_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_sts));
    // R4: at most one channel completes a reload per cycle.
    a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load_o));
endmodule

// File: tb/tmr_bus_ctl_tb_top.sv
`timescale 1ns/1ps
module tmr_bus_ctl_tb_top;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [47:0] ch_count = '0;
    logic [2:0]  ch_loaded = 3'b000;
    logic        ch2_out = 1'b0;
    logic [8:0]  ch_mode;
    logic [47:0] ch_reload;
    logic [2:0]  ch_load;
    logic        sys_wr = 1'b0;
    logic [1:0]  sys_wdata = 2'b00;
    logic [7:0]  sys_rdata;
    logic        gate2, spkr_en;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_bus_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .ch_count_i(ch_count), .ch_loaded_i(ch_loaded), .ch2_out_i(ch2_out),
        .ch_mode_o(ch_mode), .ch_reload_o(ch_reload), .ch_load_o(ch_load),
        .sysctl_wr_i(sys_wr), .sysctl_wdata_i(sys_wdata), .sysctl_rdata_o(sys_rdata),
        .gate2_o(gate2), .spkr_en_o(spkr_en)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [1:0] acc_code(input int a);
        return (a == 1) ? 2'b10 : (a == 2) ? 2'b01 : 2'b11;
    endfunction

    task automatic set_count(input int c, input logic [15:0] v);
        ch_count[c*16 +: 16] = v;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 mode", ch_mode, 0);
        chk("R1 reload", ch_reload, 0);
        chk("R1 load", ch_load, 0);
        chk("R1 gate/spkr", {gate2, spkr_en}, 0);
        ch_loaded = 3'b111;
        for (int c = 0; c < 3; c++) begin
            bus_write(2'd3, 8'hE0 | 8'(c << 1));
            bus_read(2'(c), d);
            chk("R1 R10 reset status", d, 8'h70);
        end

        // R2: command port reads zero
        bus_read(2'd3, d);
        chk("R2 command read", d, 8'h00);

        // R3 R10: sweep channel, access and mode; status reflects them
        for (int c = 0; c < 3; c++)
            for (int a = 1; a < 4; a++)
                for (int m = 0; m < 8; m++) begin
                    ch_loaded = {3{m[0]}};
                    bus_write(2'd3, 8'((c*4 + a) << 4) | 8'(m << 1));
                    chk("R3 mode out", ch_mode[c*3 +: 3], 48'(m));
                    bus_write(2'd3, 8'hE0 | 8'(c << 1));
                    bus_write(2'd3, 8'hE0 | 8'(c << 1)); // R10 second capture ignored
                    ch_loaded = {3{~m[0]}};
                    bus_read(2'(c), d);
                    chk("R10 status", d, {1'b0, m[0], acc_code(a), 3'(m), 1'b0});
                end

        // R4 R5 R6: reload assembly in each access scheme
        for (int c = 0; c < 3; c++)
            for (int a = 1; a < 4; a++)
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] lo, hi;
                    lo = 8'(8'h3C * k + c + 1);
                    hi = 8'(8'hA5 ^ (k * 17 + c));
                    bus_write(2'd3, 8'((c*4 + a) << 4));
                    if (a == 1) begin
                        bus_write(2'(c), lo);
                        chk("R4 reload", ch_reload[c*16 +: 16], {8'h00, lo});
                        chk("R4 load", ch_load, 48'(1 << c));
                    end else if (a == 2) begin
                        bus_write(2'(c), hi);
                        chk("R5 reload", ch_reload[c*16 +: 16], {hi, 8'h00});
                        chk("R5 load", ch_load, 48'(1 << c));
                    end else begin
                        bus_write(2'(c), lo);
                        chk("R6 no load after low", ch_load, 0);
                        bus_write(2'(c), hi);
                        chk("R6 reload", ch_reload[c*16 +: 16], {hi, lo});
                        chk("R6 load", ch_load, 48'(1 << c));
                    end
                end

        // R7: live reads
        for (int c = 0; c < 3; c++) begin
            logic [15:0] v;
            v = 16'hBE00 | 16'(8'hE0 + c);
            set_count(c, v);
            bus_write(2'd3, 8'((c*4 + 1) << 4));
            bus_read(2'(c), d); chk("R7 low only", d, v[7:0]);
            bus_write(2'd3, 8'((c*4 + 2) << 4));
            bus_read(2'(c), d); chk("R7 high only", d, v[15:8]);
            bus_write(2'd3, 8'((c*4 + 3) << 4));
            bus_read(2'(c), d); chk("R7 both low", d, v[7:0]);
            bus_read(2'(c), d); chk("R7 both high", d, v[15:8]);
            bus_read(2'(c), d); chk("R7 both wraps", d, v[7:0]);
        end

        // R8: per-channel latch in 16-bit and single-byte schemes
        for (int c = 0; c < 3; c++) begin
            bus_write(2'd3, 8'((c*4 + 3) << 4));
            set_count(c, 16'h1234);
            bus_write(2'd3, 8'((c*4) << 4));
            set_count(c, 16'h5678);
            bus_write(2'd3, 8'((c*4) << 4)); // ignored
            bus_read(2'(c), d); chk("R8 frozen low", d, 8'h34);
            set_count(c, 16'h9ABC);
            bus_read(2'(c), d); chk("R8 frozen high", d, 8'h12);
            bus_read(2'(c), d); chk("R8 live after", d, 8'hBC);
            bus_write(2'd3, 8'((c*4 + 2) << 4));
            bus_write(2'd3, 8'((c*4) << 4));
            set_count(c, 16'h4321);
            bus_read(2'(c), d); chk("R8 frozen msb", d, 8'h9A);
            bus_read(2'(c), d); chk("R8 released msb", d, 8'h43);
        end

        // R9: latch all channels at once
        for (int c = 0; c < 3; c++) begin
            bus_write(2'd3, 8'((c*4 + 3) << 4));
            set_count(c, 16'(16'h1111 * (c + 1)));
        end
        bus_write(2'd3, 8'hD0);
        ch_count = '1;
        for (int c = 0; c < 3; c++) begin
            logic [15:0] e;
            e = 16'(16'h1111 * (c + 1));
            bus_read(2'(c), d); chk("R9 all low", d, e[7:0]);
            bus_read(2'(c), d); chk("R9 all high", d, e[15:8]);
        end

        // R10: status comes before frozen count bytes
        ch_loaded = 3'b000;
        set_count(1, 16'hCAFE);
        bus_write(2'd3, 8'h40);
        bus_write(2'd3, 8'hE2);
        bus_read(2'd1, d); chk("R10 status first", d, 8'h30);
        bus_read(2'd1, d); chk("R10 then low", d, 8'hFE);
        bus_read(2'd1, d); chk("R10 then high", d, 8'hCA);

        // R11: access command discards half write and pending latches
        bus_write(2'd3, 8'h30);
        bus_write(2'd0, 8'h11);
        bus_write(2'd3, 8'h30);
        bus_write(2'd0, 8'h22);
        chk("R11 no load after restart", ch_load, 0);
        bus_write(2'd0, 8'h33);
        chk("R11 reload", ch_reload[15:0], 16'h3322);
        set_count(0, 16'h0F0F);
        bus_write(2'd3, 8'h00);
        bus_write(2'd3, 8'hE0);
        bus_write(2'd3, 8'h30);
        set_count(0, 16'hA1B2);
        bus_read(2'd0, d); chk("R11 latches dropped", d, 8'hB2);

        // R12: system control register
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sys_wdata = 2'(v); sys_wr = 1'b1; ch2_out = v[2];
            @(negedge clk);
            sys_wr = 1'b0;
            chk("R12 gate", gate2, 48'(v & 1));
            chk("R12 speaker", spkr_en, 48'((v >> 1) & 1));
            chk("R12 readback", sys_rdata, 48'({v[2], 5'b0} | (v & 3)));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule